// File: doc/BRIEF.md
# Sticky Error Status Register

This block collects the error and status information of a multi-channel pulse generator and presents it to a management bus as three readable registers. Each channel has a hold-off window after a pulse, during which further pulses are rejected. A pulse that lands inside that window is recorded as a missed pulse, in a sticky flag for that channel. The block also holds two sticky bus errors. One records a watchdog timeout on the management bus. The other records an access to a register address that does not exist. All sticky flags stay set until software writes a one to the bit.

A read-only identification register reports the firmware release as a byte, the presence of the timing network module, and the state of the board switches. The release byte uses one nibble per number, each read as a decimal value: 0x2E is release 2.14.

The register port is a plain write strobe with an address and a data word. Read data is combinational from the address, so it is valid in the same cycle the address is presented. Flags change on the clock edge that samples their event or clear.

Top module: `esr_status_top`

## Requirements
- R1: While `rst` is high at a clock edge, every sticky flag (both bus flags and all missed-pulse bits) is cleared to 0 by that edge.
- R2: When `pulse_i[c]` and `reject_i[c]` are both high at a clock edge, bit c of the missed-pulse register (address 2, bits NUM_CH-1..0) reads 1 after that edge. Bit 0 belongs to channel 1, bit 1 to channel 2, and so on, and no other bit changes.
- R3: A pulse without an active rejection window sets no missed-pulse bit. A rejection window without a pulse also sets no missed-pulse bit.
- R4: A one-cycle high on `bus_timeout_i` sets the timeout flag, which reads at address 1 bit 0 after that edge.
- R5: A one-cycle high on `bus_badaddr_i` sets the bad-address flag, which reads at address 1 bit 1 after that edge.
- R6: A write with a 1 in a flag's bit position at that flag's address clears the flag at that edge. A write with a 0 in that position leaves the flag unchanged.
- R7: If a set event and a clearing write hit the same flag in the same cycle, the flag reads 1 afterwards.
- R8: Address 0 reads the release byte in bits 7..0, with the major number in 7..4 and the minor number in 3..0. It reads `present_i` in bit 8 and `switch_i` in bits 16+NUM_SW-1..16. Writes to address 0 change nothing.
- R9: Addresses other than 0, 1 and 2 read as all zeros. Bits that no field occupies also read as 0.
- R10: A set flag stays set once its event input returns low, for as long as no clearing write reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | NUM_CH | Per-channel pulse strobe |
| reject_i | input | NUM_CH | Per-channel hold-off window active |
| bus_timeout_i | input | 1 | Bus watchdog timeout pulse |
| bus_badaddr_i | input | 1 | Access-to-missing-address pulse |
| present_i | input | 1 | Timing network module present |
| switch_i | input | NUM_SW | Board switch levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wdata_i | input | DATA_W | Write data; a 1 clears the matching flag |
| rdata_o | output | DATA_W | Read data for `addr_i` |

## Verification
Every flag result is due one clock edge after its stimulus. The event or clearing write is driven on a falling edge, the rising edge registers it, and the readback is taken on the following falling edge. Identification fields and zero reads are combinational, so the bench samples them one nanosecond after it changes the address, with no edge in between. Each scenario task reads through the address port in that half cycle. Each task deasserts its strobes before sampling, so no result depends on a second edge.

// File: rtl/esr_pkg.sv
package esr_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam int ID_VER_LSB  = 0;
    localparam int ID_PRES_BIT = 8;
    localparam int ID_SW_LSB   = 16;

    localparam int ERR_TO_BIT = 0;
    localparam int ERR_BA_BIT = 1;
    localparam int ERR_W      = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ID   = 4'h0,
        REG_ERR  = 4'h1,
        REG_MISS = 4'h2
    } esr_addr_e;

    typedef struct packed {
        logic       present;
        logic [7:0] version;
    } esr_id_t;

    function automatic logic [7:0] release_byte(input int major, input int minor);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = 4'(major);
        lo = 4'(minor);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/esr_w1c_bank.sv
module esr_w1c_bank #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[b] <= 1'b0;
            else if (set_i[b])
                q_o[b] <= 1'b1;        // set has priority over clear
            else if (clr_i[b])
                q_o[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/esr_miss_detect.sv
module esr_miss_detect #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] pulse_i,
    input  logic [NUM_CH-1:0] reject_i,
    output logic [NUM_CH-1:0] miss_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign miss_o[c] = pulse_i[c] & reject_i[c];
    end

endmodule

// File: rtl/esr_read_mux.sv
module esr_read_mux
    import esr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int NUM_SW = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  esr_id_t           id_i,
    input  logic [NUM_SW-1:0] switch_i,
    input  logic [ERR_W-1:0]  err_i,
    input  logic [NUM_CH-1:0] miss_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_ID: begin
                rdata_o[ID_VER_LSB +: 8]      = id_i.version;
                rdata_o[ID_PRES_BIT]          = id_i.present;
                rdata_o[ID_SW_LSB +: NUM_SW]  = switch_i;
            end
            REG_ERR:  rdata_o[ERR_W-1:0]  = err_i;
            REG_MISS: rdata_o[NUM_CH-1:0] = miss_i;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/esr_status_top.sv
module esr_status_top
    import esr_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int NUM_SW    = 4,
    parameter int VER_MAJOR = 2,
    parameter int VER_MINOR = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pulse_i,
    input  logic [NUM_CH-1:0] reject_i,
    input  logic              bus_timeout_i,
    input  logic              bus_badaddr_i,
    input  logic              present_i,
    input  logic [NUM_SW-1:0] switch_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [7:0] VERSION = release_byte(VER_MAJOR, VER_MINOR);

    logic [NUM_CH-1:0] miss_evt;
    logic [NUM_CH-1:0] miss_clr;
    logic [NUM_CH-1:0] miss_q;
    logic [ERR_W-1:0]  err_set;
    logic [ERR_W-1:0]  err_clr;
    logic [ERR_W-1:0]  err_q;
    esr_id_t           id;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CH];

    esr_miss_detect #(.NUM_CH(NUM_CH)) u_detect (
        .pulse_i  (pulse_i),
        .reject_i (reject_i),
        .miss_o   (miss_evt)
    );

    assign miss_clr = (wr_en_i && addr_i == REG_MISS) ? wdata_i[NUM_CH-1:0] : '0;

    esr_w1c_bank #(.W(NUM_CH)) u_miss_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (miss_evt),
        .clr_i (miss_clr),
        .q_o   (miss_q)
    );

    always_comb begin
        err_set             = '0;
        err_set[ERR_TO_BIT] = bus_timeout_i;
        err_set[ERR_BA_BIT] = bus_badaddr_i;
    end

    assign err_clr = (wr_en_i && addr_i == REG_ERR) ? wdata_i[ERR_W-1:0] : '0;

    esr_w1c_bank #(.W(ERR_W)) u_err_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (err_set),
        .clr_i (err_clr),
        .q_o   (err_q)
    );

    assign id.present = present_i;
    assign id.version = VERSION;

    esr_read_mux #(.NUM_CH(NUM_CH), .NUM_SW(NUM_SW)) u_rmux (
        .addr_i   (addr_i),
        .id_i     (id),
        .switch_i (switch_i),
        .err_i    (err_q),
        .miss_i   (miss_q),
        .rdata_o  (rdata_o)
    );

endmodule

// File: rtl/esr_status_checker.sv
module esr_status_checker
    import esr_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] pulse_i,
    input logic [NUM_CH-1:0] reject_i,
    input logic              bus_timeout_i,
    input logic              bus_badaddr_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [NUM_CH-1:0] miss_q,
    input logic [ERR_W-1:0]  err_q
);

    logic to_clr;
    logic [NUM_CH-1:0] hit;
    assign to_clr = wr_en_i && addr_i == REG_ERR && wdata_i[ERR_TO_BIT];
    assign hit    = pulse_i & reject_i;

    // R1: reset empties every flag
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (miss_q == '0 && err_q == '0));

    // R2 and R7: a hit sets its channel bit even under a clearing write
    p_miss_set_r2: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((miss_q & $past(hit)) == $past(hit)));

    // R3: with no hit and no write, a clear missed-pulse vector stays clear
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        (hit == '0 && miss_q == '0) |=> (miss_q == '0));

    // R4: timeout pulse latches
    p_timeout_set_r4: assert property (@(posedge clk) disable iff (rst)
        bus_timeout_i |=> err_q[ERR_TO_BIT]);

    // R5: bad-address pulse latches
    p_badaddr_set_r5: assert property (@(posedge clk) disable iff (rst)
        bus_badaddr_i |=> err_q[ERR_BA_BIT]);

    // R6: write-one clears when no new event arrives
    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (to_clr && !bus_timeout_i) |=> !err_q[ERR_TO_BIT]);

    // R10: flag holds without a clear
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (err_q[ERR_TO_BIT] && !to_clr) |=> err_q[ERR_TO_BIT]);

    // R9: unmapped addresses read zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (addr_i > ADDR_W'(REG_MISS)) |-> (rdata_o == '0));

endmodule

bind esr_status_top esr_status_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pulse_i       (pulse_i),
    .reject_i      (reject_i),
    .bus_timeout_i (bus_timeout_i),
    .bus_badaddr_i (bus_badaddr_i),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .rdata_o       (rdata_o),
    .miss_q        (miss_q),
    .err_q         (err_q)
);

// File: tb/esr_status_top_test.sv
module esr_status_top_test;

    localparam int NCH = 6;
    localparam int NSW = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] pulse_i;
    logic [NCH-1:0] reject_i;
    logic           bus_timeout_i;
    logic           bus_badaddr_i;
    logic           present_i;
    logic [NSW-1:0] switch_i;
    logic           wr_en_i;
    logic [3:0]     addr_i;
    logic [31:0]    wdata_i;
    logic [31:0]    rdata_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    esr_status_top #(.NUM_CH(NCH), .NUM_SW(NSW), .VER_MAJOR(2), .VER_MINOR(14)) uut (
        .clk           (clk),
        .rst           (rst),
        .pulse_i       (pulse_i),
        .reject_i      (reject_i),
        .bus_timeout_i (bus_timeout_i),
        .bus_badaddr_i (bus_badaddr_i),
        .present_i     (present_i),
        .switch_i      (switch_i),
        .wr_en_i       (wr_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .rdata_o       (rdata_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    // drive one cycle of stimulus on a falling edge, register it, return at next falling edge
    task automatic cycle(input logic [NCH-1:0] p, input logic [NCH-1:0] r,
                         input logic to, input logic ba,
                         input logic we, input logic [3:0] a, input logic [31:0] wd);
        @(negedge clk);
        pulse_i = p; reject_i = r; bus_timeout_i = to; bus_badaddr_i = ba;
        wr_en_i = we; addr_i = a; wdata_i = wd;
        @(posedge clk);
        @(negedge clk);
        pulse_i = '0; reject_i = '0; bus_timeout_i = 0; bus_badaddr_i = 0;
        wr_en_i = 0; wdata_i = '0;
    endtask

    task automatic do_reset();
        logic [31:0] d;
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        read_reg(4'h1, d); check("R1 err after reset", d, 32'h0);
        read_reg(4'h2, d); check("R1 miss after reset", d, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] d;
        present_i = 1; switch_i = 4'hA;
        read_reg(4'h0, d); check("R8 id present", d, 32'h000A_012E);
        present_i = 0; switch_i = 4'h5;
        read_reg(4'h0, d); check("R8 id absent", d, 32'h0005_002E);
        cycle('0, '0, 0, 0, 1, 4'h0, 32'hFFFF_FFFF);
        read_reg(4'h0, d); check("R8 write ignored", d, 32'h0005_002E);
    endtask

    task automatic t_miss();
        logic [31:0] d;
        cycle(6'b000001, 6'b000001, 0, 0, 0, 4'h2, 0);
        read_reg(4'h2, d); check("R2 channel 1 -> bit 0", d, 32'h01);
        cycle(6'b100000, 6'b100000, 0, 0, 0, 4'h2, 0);
        read_reg(4'h2, d); check("R2 channel 6 -> bit 5", d, 32'h21);
        cycle(6'b000100, 6'b000000, 0, 0, 0, 4'h2, 0);
        read_reg(4'h2, d); check("R3 pulse without window", d, 32'h21);
        cycle(6'b000000, 6'b001000, 0, 0, 0, 4'h2, 0);
        read_reg(4'h2, d); check("R3 window without pulse", d, 32'h21);
        cycle(6'b010000, 6'b000010, 0, 0, 0, 4'h2, 0);
        read_reg(4'h2, d); check("R3 mismatched channels", d, 32'h21);
        repeat (3) @(negedge clk);
        read_reg(4'h2, d); check("R10 miss sticky", d, 32'h21);
        cycle('0, '0, 0, 0, 1, 4'h2, 32'h0000_0020);
        read_reg(4'h2, d); check("R6 clear bit 5 only", d, 32'h01);
        cycle('0, '0, 0, 0, 1, 4'h2, 32'h0);
        read_reg(4'h2, d); check("R6 write zero no effect", d, 32'h01);
        cycle('0, '0, 0, 0, 1, 4'h1, 32'h1);
        read_reg(4'h2, d); check("R6 clear at other address", d, 32'h01);
        cycle(6'b000100, 6'b000100, 0, 0, 1, 4'h2, 32'h0000_0005);
        read_reg(4'h2, d); check("R7 set beats clear", d, 32'h04);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        cycle('0, '0, 1, 0, 0, 4'h1, 0);
        read_reg(4'h1, d); check("R4 timeout flag", d, 32'h1);
        cycle('0, '0, 0, 1, 0, 4'h1, 0);
        read_reg(4'h1, d); check("R5 bad-address flag", d, 32'h3);
        repeat (4) @(negedge clk);
        read_reg(4'h1, d); check("R10 bus flags sticky", d, 32'h3);
        cycle('0, '0, 0, 0, 1, 4'h1, 32'h2);
        read_reg(4'h1, d); check("R6 clear bad-address", d, 32'h1);
        cycle('0, '0, 1, 0, 1, 4'h1, 32'h1);
        read_reg(4'h1, d); check("R7 timeout set beats clear", d, 32'h1);
        cycle('0, '0, 0, 0, 1, 4'h1, 32'h3);
        read_reg(4'h1, d); check("R6 clear timeout", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        cycle(6'b000010, 6'b000010, 1, 1, 0, 4'h3, 0);
        for (int a = 3; a < 16; a++) begin
            read_reg(4'(a), d); check("R9 unmapped reads zero", d, 32'h0);
        end
        read_reg(4'h1, d); check("R9 unused error bits zero", d & 32'hFFFF_FFFC, 32'h0);
        read_reg(4'h2, d); check("R9 unused miss bits zero", d & 32'hFFFF_FFC0, 32'h0);
        cycle(6'b000010, 6'b000010, 0, 0, 0, 4'h2, 0);
        do_reset();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; pulse_i = '0; reject_i = '0; bus_timeout_i = 0; bus_badaddr_i = 0;
        present_i = 0; switch_i = '0; wr_en_i = 0; addr_i = '0; wdata_i = '0;
        repeat (2) @(posedge clk);
        do_reset();
        t_id();
        t_miss();
        t_bus();
        t_unmapped();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule